// File: doc/BRIEF.md
# USB Charger-Type Detection Sequencer

This block steps an upstream USB port through a fixed series of charger-detection measurements and reduces the result to a 3-bit charger-type code. Digitized comparator flags describe the data lines: a low-resistance short between DP and DM, the DP voltage reflected onto DM, pull-downs on both lines, and four level flags (DP near 2.0 V, DP near 2.7 V, DM near 2.0 V, DM near 2.7 V). The `meas_step` output tells the analog front end which measurement to set up.

A run starts when the hub signals entry into its charger-detect stage while detection is enabled. Each step counts a programmable number of timer ticks so the lines can settle, then samples its comparator flags. The first step that matches ends the run. The code is latched into the status output and a sticky interrupt is raised, which software clears by writing 1. The timer tick comes from the reference time base or from a toggling internal-oscillator signal, so detection still works when the reference clock is absent.

Top module: `chgdet_seq`

## Requirements
- R1: A short between the lines (`cmp_short`=1) in the first step ends the run with type 3'b001.
- R2: A reflected voltage (`cmp_reflect`=1) gives type 3'b010, but only when `enh_en` was 1 at the start of the run. Otherwise the reflect step is skipped and 3'b010 is never reported.
- R3: The level signatures map as follows, with exactly the two named flags set: DP 2.0 V and DM 2.0 V gives 3'b100, DP 2.0 V and DM 2.7 V gives 3'b101, and DP 2.7 V and DM 2.0 V gives 3'b110. Any other combination of level flags is no match.
- R4: The last step reports 3'b011 if `cmp_pd`=1 and 3'b000 if nothing matched.
- R5: Priority order is short, then reflect, then signature, then pull-down. The first match wins.
- R6: A run starts on `stage_enter` only while `det_en`=1 and no run is active. A `stage_enter` pulse during a run, or while `det_en`=0, is ignored.
- R7: Each step samples on the S-th tick after it begins, where S = `settle_ticks` and S=0 acts as 1. With a tick in every cycle, `busy` stays high for (steps evaluated)×max(S,1) cycles.
- R8: `irq` goes to 1 in the cycle the result is latched and holds until `irq_clr`=1. If a completion and a clear fall in the same cycle, the set wins.
- R9: After reset `chg_type`=000, `irq`=0 and `busy`=0. `chg_type` changes only when a run completes.
- R10: With `use_osc`=1, ticks are the synchronized edges of `osc_toggle` and `ref_tick` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| det_en | input | 1 | Detection enable |
| enh_en | input | 1 | Enables reflect-step recognition, latched at start |
| stage_enter | input | 1 | Pulse when the hub enters its charger-detect stage |
| settle_ticks | input | SETTLE_W | Ticks per step before sampling, latched at start |
| use_osc | input | 1 | Selects the internal-oscillator tick |
| ref_tick | input | 1 | Reference tick pulse |
| osc_toggle | input | 1 | Asynchronous oscillator toggle; each edge is one tick |
| cmp_short | input | 1 | DP/DM short detected |
| cmp_reflect | input | 1 | DP voltage seen on DM |
| cmp_pd | input | 1 | Pull-downs on both lines |
| dp_2v0 | input | 1 | DP near 2.0 V |
| dp_2v7 | input | 1 | DP near 2.7 V |
| dm_2v0 | input | 1 | DM near 2.0 V |
| dm_2v7 | input | 1 | DM near 2.7 V |
| irq_clr | input | 1 | Write-1-to-clear for the interrupt |
| meas_step | output | 2 | Active measurement: 0 short, 1 reflect, 2 signature, 3 pull-down |
| busy | output | 1 | A run is in progress |
| chg_type | output | 3 | Latched charger-type code |
| irq | output | 1 | Result-ready interrupt |

## Verification
The bench builds the block with `SETTLE_W`=4. Settle counts of 0, 1, 3, 5 and the maximum of 15 are all reachable with this setting, and the longest four-step run is only 60 cycles, so every run's length can be compared exactly against steps×max(S,1). With the reference tick held high, each run's duration shows exactly which steps were evaluated. That makes the reflect-step skip with `enh_en`=0 and the first-match priority observable at the ports, in addition to the reported code.

// File: rtl/chgdet_pkg.sv
package chgdet_pkg;

    typedef enum logic [1:0] {
        STEP_SHORT = 2'd0,
        STEP_REFL  = 2'd1,
        STEP_SIG   = 2'd2,
        STEP_PD    = 2'd3
    } step_e;

    localparam logic [2:0] TYPE_NONE  = 3'b000;
    localparam logic [2:0] TYPE_DEDIC = 3'b001;
    localparam logic [2:0] TYPE_CHGDN = 3'b010;
    localparam logic [2:0] TYPE_STDDN = 3'b011;
    localparam logic [2:0] TYPE_PLOW  = 3'b100;
    localparam logic [2:0] TYPE_PHIGH = 3'b101;
    localparam logic [2:0] TYPE_PSUP  = 3'b110;

    // Level-signature decode; exactly two flags must be present.
    function automatic logic [2:0] sig_decode(input logic dp20, input logic dp27,
                                              input logic dm20, input logic dm27);
        logic [3:0] v;
        v = {dp20, dp27, dm20, dm27};
        case (v)
            4'b1010: return TYPE_PLOW;
            4'b1001: return TYPE_PHIGH;
            4'b0110: return TYPE_PSUP;
            default: return TYPE_NONE;
        endcase
    endfunction

endpackage

// File: rtl/chgdet_tick_src.sv
module chgdet_tick_src (
    input  logic clk,
    input  logic rst_n,
    input  logic use_osc,
    input  logic ref_tick,
    input  logic osc_toggle,
    output logic tick
);
    localparam int SYNC_N = 3;

    logic [SYNC_N-1:0] sync_q, sync_d;

    always_comb begin
        sync_d = {sync_q[SYNC_N-2:0], osc_toggle};
        tick   = use_osc ? (sync_q[SYNC_N-1] ^ sync_q[SYNC_N-2]) : ref_tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end
endmodule

// File: rtl/chgdet_settle_timer.sv
module chgdet_settle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         done
);
    localparam int CW = W + 1;

    logic [W-1:0]  cnt_q, cnt_d;
    logic [CW-1:0] nxt;

    always_comb begin
        nxt   = {1'b0, cnt_q} + CW'(1);
        done  = en && tick && (nxt >= {1'b0, limit});
        cnt_d = cnt_q;
        if (clr)            cnt_d = '0;
        else if (en && tick) cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/chgdet_seq.sv
module chgdet_seq
    import chgdet_pkg::*;
#(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                det_en,
    input  logic                enh_en,
    input  logic                stage_enter,
    input  logic [SETTLE_W-1:0] settle_ticks,
    input  logic                use_osc,
    input  logic                ref_tick,
    input  logic                osc_toggle,
    input  logic                cmp_short,
    input  logic                cmp_reflect,
    input  logic                cmp_pd,
    input  logic                dp_2v0,
    input  logic                dp_2v7,
    input  logic                dm_2v0,
    input  logic                dm_2v7,
    input  logic                irq_clr,
    output logic [1:0]          meas_step,
    output logic                busy,
    output logic [2:0]          chg_type,
    output logic                irq
);
    typedef struct packed {
        logic                busy;
        step_e               step;
        logic                enh;
        logic [SETTLE_W-1:0] settle;
        logic [2:0]          typ;
        logic                irq;
    } seq_t;

    seq_t q, d;
    logic tick, settled, advance, finish;
    logic [2:0] code, sig;

    chgdet_tick_src u_tick (
        .clk(clk), .rst_n(rst_n), .use_osc(use_osc),
        .ref_tick(ref_tick), .osc_toggle(osc_toggle), .tick(tick)
    );

    chgdet_settle_timer #(.W(SETTLE_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .en(q.busy), .clr(advance),
        .tick(tick), .limit(q.settle), .done(settled)
    );

    always_comb begin
        d       = q;
        advance = 1'b0;
        finish  = 1'b0;
        code    = TYPE_NONE;
        sig     = sig_decode(dp_2v0, dp_2v7, dm_2v0, dm_2v7);

        if (!q.busy && stage_enter && det_en) begin
            // R6: accept start only when idle and enabled
            d.busy   = 1'b1;
            d.step   = STEP_SHORT;
            d.enh    = enh_en;
            d.settle = settle_ticks;
            advance  = 1'b1;
        end else if (q.busy && settled) begin
            advance = 1'b1;
            unique case (q.step)
                STEP_SHORT: begin
                    if (cmp_short) begin finish = 1'b1; code = TYPE_DEDIC; end
                    else d.step = q.enh ? STEP_REFL : STEP_SIG;   // R2 skip
                end
                STEP_REFL: begin
                    if (cmp_reflect) begin finish = 1'b1; code = TYPE_CHGDN; end
                    else d.step = STEP_SIG;
                end
                STEP_SIG: begin
                    if (sig != TYPE_NONE) begin finish = 1'b1; code = sig; end
                    else d.step = STEP_PD;
                end
                STEP_PD: begin
                    finish = 1'b1;
                    code   = cmp_pd ? TYPE_STDDN : TYPE_NONE;
                end
                default: ;
            endcase
        end

        if (finish) begin
            d.busy = 1'b0;
            d.typ  = code;
        end
        // R8: set has priority over the write-1 clear
        d.irq = finish | (q.irq & ~irq_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.busy   <= 1'b0;
            q.step   <= STEP_SHORT;
            q.enh    <= 1'b0;
            q.settle <= '0;
            q.typ    <= TYPE_NONE;
            q.irq    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign meas_step = q.step;
    assign busy      = q.busy;
    assign chg_type  = q.typ;
    assign irq       = q.irq;
endmodule

// File: rtl/chgdet_seq_chk.sv
module chgdet_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       irq,
    input logic       irq_clr,
    input logic [2:0] chg_type,
    input logic       det_en,
    input logic       enh_en
);
    logic enh_snap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     enh_snap <= 1'b0;
        else if (!busy) enh_snap <= enh_en;
    end

    p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !irq_clr |=> irq);

    p_irq_rise_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $fell(busy));

    p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq && irq_clr && !busy |=> !irq);

    p_type_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(chg_type));

    p_no_cdp_without_enh_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) && !enh_snap |-> chg_type != 3'b010);

    p_disabled_no_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !det_en |=> !busy);
endmodule

bind chgdet_seq chgdet_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .irq(irq), .irq_clr(irq_clr),
    .chg_type(chg_type), .det_en(det_en), .enh_en(enh_en)
);

// File: tb/chgdet_seq_test.sv
module chgdet_seq_test;
    localparam int SW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic det_en = 1'b0, enh_en = 1'b0, stage_enter = 1'b0;
    logic [SW-1:0] settle_ticks = '0;
    logic use_osc = 1'b0, ref_tick = 1'b1, osc_toggle = 1'b0;
    logic cmp_short = 0, cmp_reflect = 0, cmp_pd = 0;
    logic dp_2v0 = 0, dp_2v7 = 0, dm_2v0 = 0, dm_2v7 = 0;
    logic irq_clr = 1'b0;
    logic [1:0] meas_step;
    logic busy, irq;
    logic [2:0] chg_type;

    always #2 clk = ~clk;   // 250 MHz

    chgdet_seq #(.SETTLE_W(SW)) uut (
        .clk(clk), .rst_n(rst_n), .det_en(det_en), .enh_en(enh_en),
        .stage_enter(stage_enter), .settle_ticks(settle_ticks),
        .use_osc(use_osc), .ref_tick(ref_tick), .osc_toggle(osc_toggle),
        .cmp_short(cmp_short), .cmp_reflect(cmp_reflect), .cmp_pd(cmp_pd),
        .dp_2v0(dp_2v0), .dp_2v7(dp_2v7), .dm_2v0(dm_2v0), .dm_2v7(dm_2v7),
        .irq_clr(irq_clr), .meas_step(meas_step), .busy(busy),
        .chg_type(chg_type), .irq(irq)
    );

    typedef struct {
        logic [2:0] code;
        int         len;    // 0: length not checked
        string      req;
    } exp_t;

    exp_t exp_q[$];
    int vectors = 0;
    int errors  = 0;
    bit osc_run = 1'b0;
    bit done_flag = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Monitor: pops expected items when a run ends
    int  run_len = 0;
    logic prev_busy = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) run_len++;
            if (prev_busy && !busy) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6", "unexpected completion", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(chg_type == e.code, e.req, "chg_type", chg_type, e.code);
                    check(irq == 1'b1, "R8", "irq at completion", irq, 1);
                    if (e.len != 0)
                        check(run_len == e.len, "R7", "run length", run_len, e.len);
                end
                run_len = 0;
            end
            prev_busy = busy;
        end
    end

    always begin
        repeat (3) @(negedge clk);
        if (osc_run) osc_toggle = ~osc_toggle;
    end

    // Driver: flags = {short, reflect, pd, dp20, dp27, dm20, dm27}
    task automatic run(input logic [6:0] flags, input logic enh, input int s,
                       input logic [2:0] code, input int steps, input string req,
                       input bit chk_len);
        exp_t e;
        @(negedge clk);
        {cmp_short, cmp_reflect, cmp_pd, dp_2v0, dp_2v7, dm_2v0, dm_2v7} = flags;
        enh_en = enh;
        settle_ticks = SW'(s);
        e.code = code;
        e.len  = chk_len ? steps * ((s == 0) ? 1 : s) : 0;
        e.req  = req;
        exp_q.push_back(e);
        stage_enter = 1'b1;
        @(negedge clk);
        stage_enter = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, req, "run completed", exp_q.size(), 0);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            vectors++; errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check(chg_type == 3'b000, "R9", "reset chg_type", chg_type, 0);
        check(irq == 1'b0, "R9", "reset irq", irq, 0);
        check(busy == 1'b0, "R9", "reset busy", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: disabled detection ignores the stage pulse
        det_en = 1'b0; cmp_short = 1'b1;
        stage_enter = 1'b1; @(negedge clk); stage_enter = 1'b0;
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R6", "no start when disabled", busy, 0);
        check(chg_type == 3'b000, "R6", "type untouched when disabled", chg_type, 0);
        det_en = 1'b1;

        run(7'b1000000, 1'b1, 1, 3'b001, 1, "R1", 1'b1);
        run(7'b0100000, 1'b1, 3, 3'b010, 2, "R2", 1'b1);
        run(7'b0110000, 1'b0, 2, 3'b011, 3, "R2", 1'b1);   // reflect skipped
        run(7'b0001010, 1'b1, 1, 3'b100, 3, "R3", 1'b1);
        run(7'b0001001, 1'b0, 1, 3'b101, 2, "R3", 1'b1);
        run(7'b0000110, 1'b1, 2, 3'b110, 3, "R3", 1'b1);
        run(7'b0010101, 1'b1, 1, 3'b011, 4, "R3", 1'b1);   // invalid signature
        run(7'b0010000, 1'b1, 5, 3'b011, 4, "R4", 1'b1);
        run(7'b0000000, 1'b1, 0, 3'b000, 4, "R4", 1'b1);
        run(7'b1110000, 1'b1, 2, 3'b001, 1, "R5", 1'b1);
        run(7'b0101010, 1'b1, 1, 3'b010, 2, "R5", 1'b1);
        run(7'b0011001, 1'b1, 1, 3'b101, 3, "R5", 1'b1);
        run(7'b0000000, 1'b1, 15, 3'b000, 4, "R7", 1'b1);

        // R9: type holds between runs
        repeat (5) @(negedge clk);
        check(chg_type == 3'b000, "R9", "type held idle", chg_type, 0);

        // R8: irq held without clear, cleared by write 1
        run_noclr();
        repeat (4) @(negedge clk);
        check(irq == 1'b1, "R8", "irq sticky", irq, 1);
        check(chg_type == 3'b001, "R9", "type held after run", chg_type, 1);
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0; @(negedge clk);
        check(irq == 1'b0, "R8", "irq cleared", irq, 0);

        // R8: set wins over clear at completion, then clear applies
        irq_clr = 1'b1;
        run(7'b0010000, 1'b1, 2, 3'b011, 4, "R8", 1'b1);
        irq_clr = 1'b0;
        check(irq == 1'b0, "R8", "irq cleared after set-wins", irq, 0);

        // R6: stage pulse during a run is ignored
        fork
            run(7'b0000000, 1'b1, 5, 3'b000, 4, "R6", 1'b1);
            begin
                repeat (6) @(negedge clk);
                stage_enter = 1'b1; @(negedge clk); stage_enter = 1'b0;
            end
        join
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R6", "no restart from mid-run pulse", busy, 0);

        // R10: oscillator tick source, reference tick held off
        use_osc = 1'b1; ref_tick = 1'b0; osc_run = 1'b1;
        run(7'b0001010, 1'b1, 2, 3'b100, 3, "R10", 1'b0);
        osc_run = 1'b0;
        @(negedge clk);
        cmp_short = 1'b1; settle_ticks = SW'(1);
        stage_enter = 1'b1; @(negedge clk); stage_enter = 1'b0;
        repeat (8) @(negedge clk);
        check(busy == 1'b1, "R10", "ref_tick ignored, no osc edges", busy, 1);

        done_flag = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    task automatic run_noclr();
        exp_t e;
        @(negedge clk);
        {cmp_short, cmp_reflect, cmp_pd, dp_2v0, dp_2v7, dm_2v0, dm_2v7} = 7'b1000000;
        settle_ticks = SW'(1);
        e.code = 3'b001; e.len = 1; e.req = "R1";
        exp_q.push_back(e);
        stage_enter = 1'b1; @(negedge clk); stage_enter = 1'b0;
        while (busy) @(negedge clk);
    endtask
endmodule